// File: doc/BRIEF.md
# Filtered Gated Edge Event Counter

This block counts transitions on an asynchronous digital source line into a 64-bit register, making one counting decision per clock. The source and a gate line each pass through a two-flop synchroniser. The source then goes through a stability filter, which accepts a new level only after it has held for a programmed number of clock ticks. An edge detector picks out rising or falling transitions. When gating is enabled, an edge counts only while the gate is high. Each counted edge moves the register up or down by one.

A run input separates two phases. While run is low, the block captures its configuration inputs, counting stops and the register is reloaded: it goes to zero for counting up, or to the programmed terminal value for counting down. While run is high, the captured configuration is used and any change on the configuration inputs has no effect. A one-clock strobe marks the cycle in which the register arrives at its end point. That end point is the terminal value when counting up and zero when counting down.

Top module: `edge_event_counter`

## Requirements
- R1: After an asynchronous active-low reset, `count_q` is 0 and `tc_pulse` is 0.
- R2: With filter length N (`cfg_filter`), a source level must be sampled on N consecutive clocks to be accepted. A high pulse lasting fewer than N clocks produces no count, and one lasting N or more clocks is counted. N of 0 and N of 1 both accept a level held for a single clock.
- R3: `cfg_falling` = 0 counts low-to-high transitions of the filtered source, and `cfg_falling` = 1 counts high-to-low transitions.
- R4: With `cfg_gate_en` = 1, an edge is counted only while the synchronised `gate_in` is 1. With `cfg_gate_en` = 0, `gate_in` has no effect.
- R5: `cfg_down` = 0 adds one per counted edge and `cfg_down` = 1 subtracts one, modulo 2^64. Decrementing from 0 gives 2^64-1.
- R6: On every clock where `run` = 0, no edge is counted and `count_q` is loaded with 0 (if `cfg_down` = 0) or with `cfg_terminal` (if `cfg_down` = 1). If `run` falls on the clock where an edge would be counted, the reload takes precedence.
- R7: `tc_pulse` is 1 for exactly one clock, in the same cycle that `count_q` first shows the end point: `cfg_terminal` when counting up, 0 when counting down. It stays 0 while `run` = 0.
- R8: The configuration inputs are captured only on clocks where `run` = 0. Changes made to them while `run` = 1 do not alter counting.
- R9: With N of at most 1, a source change applied before clock edge 1 shows up in `count_q` after clock edge 4. Each additional filter tick adds one clock, so the update comes after edge N+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | 1 = counting enabled, 0 = halt, reload and capture configuration |
| cfg_falling | input | 1 | Edge polarity select, 1 = falling |
| cfg_down | input | 1 | Count direction, 1 = decrement |
| cfg_gate_en | input | 1 | 1 = gate qualifies counting |
| cfg_terminal | input | CNT_W | Terminal value |
| cfg_filter | input | FILT_W | Filter length in clock ticks |
| src_in | input | 1 | Asynchronous source line |
| gate_in | input | 1 | Asynchronous gate line |
| count_q | output | CNT_W | Live count register |
| tc_pulse | output | 1 | End-point strobe |

## Verification
A stop request and a counted edge can arrive in the same clock. The bench provokes this by raising the source and then lowering run exactly before the fourth clock edge, which is the edge on which the count would otherwise advance. It expects the reload value in `count_q` and no strobe, even though the programmed terminal is one step away. Separately, the cycle in which the strobe rises is compared against the cycle in which the register arrives at the terminal value, in both directions.

// File: rtl/edge_event_counter.sv
module edge_event_counter #(
  parameter int CNT_W       = 64,
  parameter int FILT_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              cfg_falling,
  input  logic              cfg_down,
  input  logic              cfg_gate_en,
  input  logic [CNT_W-1:0]  cfg_terminal,
  input  logic [FILT_W-1:0] cfg_filter,
  input  logic              src_in,
  input  logic              gate_in,
  output logic [CNT_W-1:0]  count_q,
  output logic              tc_pulse
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  // captured configuration
  logic              falling_q, down_q, gate_en_q;
  logic [CNT_W-1:0]  term_q;
  logic [FILT_W-1:0] flen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      falling_q <= 1'b0;
      down_q    <= 1'b0;
      gate_en_q <= 1'b0;
      term_q    <= '0;
      flen_q    <= '0;
    end else if (!run) begin
      falling_q <= cfg_falling;
      down_q    <= cfg_down;
      gate_en_q <= cfg_gate_en;
      term_q    <= cfg_terminal;
      flen_q    <= cfg_filter;
    end
  end

  // synchronisers
  logic [SYNC_STAGES-1:0] src_sr, gate_sr;
  logic src_s, gate_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_sr  <= '0;
      gate_sr <= '0;
    end else begin
      src_sr  <= {src_sr[SYNC_STAGES-2:0], src_in};
      gate_sr <= {gate_sr[SYNC_STAGES-2:0], gate_in};
    end
  end

  assign src_s  = src_sr[SYNC_STAGES-1];
  assign gate_s = gate_sr[SYNC_STAGES-1];

  // stability filter
  logic              cand, filt, filt_d;
  logic [FILT_W-1:0] tick;
  logic [FILT_W:0]   seen;

  assign seen = (src_s == cand) ? {1'b0, tick} + 1'b1 : (FILT_W+1)'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand   <= 1'b0;
      tick   <= '0;
      filt   <= 1'b0;
      filt_d <= 1'b0;
    end else begin
      cand   <= src_s;
      tick   <= seen[FILT_W] ? '1 : seen[FILT_W-1:0];
      if (seen >= {1'b0, flen_q})
        filt <= src_s;
      filt_d <= filt;
    end
  end

  // edge selection, gating, counting
  logic              edge_hit, ev;
  logic [CNT_W-1:0]  count_nx, target;

  assign edge_hit = falling_q ? (filt_d & ~filt) : (filt & ~filt_d);
  assign ev       = edge_hit & (~gate_en_q | gate_s);
  assign count_nx = down_q ? count_q - ONE : count_q + ONE;
  assign target   = down_q ? '0 : term_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      tc_pulse <= 1'b0;
    end else if (!run) begin
      count_q  <= cfg_down ? cfg_terminal : '0;
      tc_pulse <= 1'b0;
    end else begin
      tc_pulse <= ev && (count_nx == target);
      if (ev)
        count_q <= count_nx;
    end
  end

  AST_STOP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> count_q == ($past(cfg_down) ? $past(cfg_terminal) : '0)); // R6

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + ONE) ||
            (count_q == $past(count_q) - ONE)); // R5

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    run && gate_en_q && !gate_s |=> $stable(count_q)); // R4

  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |=> !tc_pulse); // R7

  AST_TC_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !tc_pulse); // R7

  AST_TC_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    tc_pulse |-> count_q == target); // R7

endmodule

// File: tb/edge_event_counter_test.sv
module edge_event_counter_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        cfg_falling = 1'b0, cfg_down = 1'b0, cfg_gate_en = 1'b0;
  logic [63:0] cfg_terminal = 64'd0;
  logic [15:0] cfg_filter = 16'd0;
  logic        src_in = 1'b0, gate_in = 1'b0;
  logic [63:0] count_q;
  logic        tc_pulse;

  int checks = 0, fails = 0, tc_seen = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_event_counter uut (
    .clk(clk), .rst_n(rst_n), .run(run),
    .cfg_falling(cfg_falling), .cfg_down(cfg_down), .cfg_gate_en(cfg_gate_en),
    .cfg_terminal(cfg_terminal), .cfg_filter(cfg_filter),
    .src_in(src_in), .gate_in(gate_in),
    .count_q(count_q), .tc_pulse(tc_pulse)
  );

  always @(negedge clk) if (tc_pulse) tc_seen++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic setup(input logic fall, input logic dn, input logic gen, input logic glvl,
                       input logic [15:0] flen, input logic [63:0] term);
    @(negedge clk);
    run = 1'b0; cfg_falling = fall; cfg_down = dn; cfg_gate_en = gen;
    gate_in = glvl; cfg_filter = flen; cfg_terminal = term; src_in = 1'b0;
    repeat (flen + 6) @(negedge clk);
    run = 1'b1;
  endtask

  task automatic pulse(input int w, input int gap);
    @(negedge clk); src_in = 1'b1;
    repeat (w) @(negedge clk);
    src_in = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // [19] falling [18] down [17] gate_en [16] gate level [15:12] filter
  // [11:8] pulse width [7:4] pulses [3:0] expected counted edges
  localparam logic [19:0] VEC [10] = '{
    20'h0_0155, 20'h8_0233, 20'h4_0144, 20'h3_0233, 20'h2_0230,
    20'h0_4330, 20'h0_4433, 20'hF_2222, 20'h0_1122, 20'h6_3520
  };

  initial begin
    int tc0;
    repeat (3) @(negedge clk);
    chk("R1 count after reset", count_q, 64'd0);
    chk("R1 strobe after reset", {63'd0, tc_pulse}, 64'd0);
    rst_n = 1'b1;

    foreach (VEC[i]) begin
      logic [19:0] v;
      v = VEC[i];
      setup(v[19], v[18], v[17], v[16], {12'd0, v[15:12]}, 64'd200);
      tc0 = tc_seen;
      for (int p = 0; p < int'(v[7:4]); p++) pulse(int'(v[11:8]), int'(v[15:12]) + 6);
      repeat (10) @(negedge clk);
      chk($sformatf("R2 R3 R4 R5 vector %0d count", i), count_q,
          v[18] ? 64'd200 - 64'(v[3:0]) : 64'(v[3:0]));
      chk($sformatf("R7 vector %0d no strobe", i), 64'(tc_seen - tc0), 64'd0);
    end

    // R9 latency, filter 0
    setup(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 64'd100);
    src_in = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R9 no update after edge 3 (N=0)", count_q, 64'd0);
    @(posedge clk); #1;
    chk("R9 update after edge 4 (N=0)", count_q, 64'd1);

    // R9 latency, filter 3
    setup(1'b0, 1'b0, 1'b0, 1'b0, 16'd3, 64'd100);
    src_in = 1'b1;
    repeat (5) @(posedge clk); #1;
    chk("R9 no update after edge 5 (N=3)", count_q, 64'd0);
    @(posedge clk); #1;
    chk("R9 update after edge 6 (N=3)", count_q, 64'd1);

    // R7 up strobe aligned with terminal 3
    setup(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 64'd3);
    tc0 = tc_seen;
    pulse(2, 6); pulse(2, 6);
    @(negedge clk); src_in = 1'b1;
    repeat (4) @(posedge clk); #1;
    chk("R7 count at terminal", count_q, 64'd3);
    chk("R7 strobe in same cycle", {63'd0, tc_pulse}, 64'd1);
    @(posedge clk); #1;
    chk("R7 strobe one clock only", {63'd0, tc_pulse}, 64'd0);
    repeat (4) @(negedge clk); src_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R7 single strobe up", 64'(tc_seen - tc0), 64'd1);

    // R7 down reaches zero, then R5 wraps
    setup(1'b0, 1'b1, 1'b0, 1'b0, 16'd0, 64'd2);
    tc0 = tc_seen;
    pulse(2, 6); pulse(2, 6);
    chk("R5 down count to zero", count_q, 64'd0);
    chk("R7 single strobe down", 64'(tc_seen - tc0), 64'd1);
    pulse(2, 6);
    chk("R5 wrap below zero", count_q, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R7 no strobe on wrap", 64'(tc_seen - tc0), 64'd1);

    // R6 stop reloads terminal when counting down
    @(negedge clk); run = 1'b0; cfg_terminal = 64'h0123_4567_89AB_CDEF;
    @(negedge clk);
    chk("R6 reload down", count_q, 64'h0123_4567_89AB_CDEF);

    // R6 stop and edge in the same clock
    setup(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 64'd1);
    tc0 = tc_seen;
    src_in = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); run = 1'b0;
    @(posedge clk); #1;
    chk("R6 stop wins over edge", count_q, 64'd0);
    chk("R6 R7 no strobe on stop", {63'd0, tc_pulse}, 64'd0);
    @(negedge clk); src_in = 1'b0;
    repeat (6) @(negedge clk);
    chk("R7 no strobe stopped", 64'(tc_seen - tc0), 64'd0);

    // R8 and R3: config changed while running is ignored
    setup(1'b0, 1'b0, 1'b0, 1'b0, 16'd0, 64'd100);
    cfg_down = 1'b1; cfg_falling = 1'b1; cfg_gate_en = 1'b1; gate_in = 1'b0;
    cfg_filter = 16'd9;
    @(negedge clk); src_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 R3 counted on rise despite new config", count_q, 64'd1);
    src_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 R3 fall ignored", count_q, 64'd1);

    // R3 falling mode: rise leaves count, fall counts
    setup(1'b1, 1'b0, 1'b0, 1'b0, 16'd0, 64'd100);
    @(negedge clk); src_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R3 falling mode ignores rise", count_q, 64'd0);
    src_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R3 falling mode counts fall", count_q, 64'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule